// File: doc/BRIEF.md
# Shared Timer Interrupt Vector Unit

This block collects the secondary interrupt sources of a timer (compare channels 1 and 2 and the counter wrap) behind one shared interrupt request and one readable vector register. Each source has a sticky flag and its own enable. The vector output always shows a code for the highest-priority source that is both flagged and enabled. Reading that register acknowledges the interrupt: the read clears only the flag it reported. If other enabled flags are still pending, the shared request stays high so the handler is entered again.

Compare channel 0 sits outside the shared vector. It has its own flag and its own request line. Its flag is cleared by a service acknowledge strobe. The timer count is an input to the block. A flag is raised when the count steps onto a matching value. Software can also drop any shared flag directly through a write-one-to-clear strobe with a bit mask.

Top module: `timer_irq_vector`

## Requirements
- R1: A compare flag for channel k (k = 1, 2) sets in the clock edge after the count input changes to a value equal to that channel's compare value. A count that holds its value does not set the flag again.
- R2: The wrap flag sets in the clock edge after the count input changes from a nonzero value to zero.
- R3: `vec_code` reads 0x0 when no enabled flag is pending, 0x2 for channel 1, 0x4 for channel 2 and 0xA for wrap. Channel 1 has the highest priority and wrap the lowest. Only enabled flags are considered.
- R4: `irq_shared` is high exactly when at least one flag is pending with its enable bit set.
- R5: A cycle with `rd_stb` high clears only the flag whose code `vec_code` shows in that cycle. The other flags stay set, and the request stays high while any of them is enabled.
- R6: A flag whose set event arrives in the same cycle as a read or a write-one-to-clear is kept. This applies even when that same flag is the one being cleared.
- R7: A flag whose enable is low still latches its event but affects neither `vec_code` nor `irq_shared`. It becomes visible once its enable is raised.
- R8: With `w1c_stb` high, every flag whose bit is set in `w1c_mask` is cleared (bit 0 channel 1, bit 1 channel 2, bit 2 wrap). Flags whose mask bit is zero are unaffected.
- R9: Channel 0 sets its own flag on a compare match (same rule as R1), drives `irq_cc0` as flag AND `cc0_en`, and is cleared by `cc0_ack`. It never appears in `vec_code`.
- R10: After reset all flags are clear, `vec_code` is 0 and both request lines are low.
- R11: A read while `vec_code` is 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_count | input | 8 | Current timer count |
| cmp0_val | input | 8 | Channel 0 compare value |
| cmp_vals | input | 16 | Channel 1 compare value in bits 7:0, channel 2 compare value in bits 15:8 |
| cc0_en | input | 1 | Channel 0 request enable |
| cc0_ack | input | 1 | Channel 0 service acknowledge, clears its flag |
| src_en | input | 3 | Shared source enables (bit 0 ch1, bit 1 ch2, bit 2 wrap) |
| rd_stb | input | 1 | Vector register read strobe |
| w1c_stb | input | 1 | Write-one-to-clear strobe |
| w1c_mask | input | 3 | Flags to clear when `w1c_stb` is high |
| vec_code | output | 4 | Code of the highest-priority enabled pending flag |
| irq_shared | output | 1 | Shared interrupt request |
| irq_cc0 | output | 1 | Channel 0 interrupt request |

## Verification
The assertions assume that every strobe lasts one cycle and is sampled at the clock edge. They also assume that a set event is caused only by a change in the count input, so a clear with no event in the same cycle must leave the flag low. The stimulus changes inputs only at the falling edge. It moves the count to a new value at most once per cycle. It holds `rd_stb`, `w1c_stb` and `cc0_ack` for exactly one cycle. It keeps all compare values nonzero and different from one another, so that each count step causes at most the events the test expects.

// File: rtl/tiv_pkg.sv
package tiv_pkg;
  // Vector code of shared source idx: compare channels first, wrap last.
  function automatic logic [7:0] src_code(input int idx, input int n_cmp,
                                          input logic [7:0] wrap_code);
    if (idx < n_cmp) return 8'(2 * (idx + 1));
    return wrap_code;
  endfunction

  // True when the count has moved onto a matching value.
  function automatic logic step_match(input logic [15:0] cnt_now,
                                      input logic [15:0] cnt_old,
                                      input logic [15:0] target);
    return (cnt_now != cnt_old) && (cnt_now == target);
  endfunction

  // True when the count has moved from nonzero back to zero.
  function automatic logic step_wrap(input logic [15:0] cnt_now,
                                     input logic [15:0] cnt_old);
    return (cnt_now == 16'd0) && (cnt_old != 16'd0);
  endfunction
endpackage

// File: rtl/tiv_evt_det.sv
module tiv_evt_det #(
  parameter int CNT_W = 8,
  parameter int N_CMP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       count_i,
  input  logic [CNT_W-1:0]       cmp0_i,
  input  logic [N_CMP*CNT_W-1:0] cmp_i,
  output logic                   evt_cc0_o,
  output logic [N_CMP-1:0]       evt_cmp_o,
  output logic                   evt_wrap_o
);
  import tiv_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= count_i;
  end

  assign evt_cc0_o  = step_match(16'(count_i), 16'(cnt_q), 16'(cmp0_i));
  assign evt_wrap_o = step_wrap(16'(count_i), 16'(cnt_q));

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign evt_cmp_o[g] = step_match(16'(count_i), 16'(cnt_q),
                                     16'(cmp_i[g*CNT_W +: CNT_W]));
  end
endmodule

// File: rtl/tiv_flag_bank.sv
module tiv_flag_bank #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flags_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        f_q <= 1'b0;
      else if (set_i[g]) f_q <= 1'b1;   // set wins over clear
      else if (clr_i[g]) f_q <= 1'b0;
    end
    assign flags_o[g] = f_q;
  end
endmodule

// File: rtl/tiv_prio_enc.sv
module tiv_prio_enc #(
  parameter int               NF        = 3,
  parameter int               N_CMP     = 2,
  parameter int               VEC_W     = 4,
  parameter logic [VEC_W-1:0] WRAP_CODE = 4'hA
) (
  input  logic [NF-1:0]    req_i,
  output logic [NF-1:0]    sel_o,
  output logic [VEC_W-1:0] code_o
);
  import tiv_pkg::*;

  always_comb begin
    logic found;
    found  = 1'b0;
    sel_o  = '0;
    code_o = '0;
    for (int i = 0; i < NF; i++) begin
      if (req_i[i] && !found) begin
        found    = 1'b1;
        sel_o[i] = 1'b1;
        code_o   = VEC_W'(src_code(i, N_CMP, 8'(WRAP_CODE)));
      end
    end
  end
endmodule

// File: rtl/timer_irq_vector.sv
module timer_irq_vector #(
  parameter int               CNT_W     = 8,
  parameter int               N_CMP     = 2,
  parameter int               VEC_W     = 4,
  parameter logic [VEC_W-1:0] WRAP_CODE = 4'hA
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_W-1:0]       tmr_count,
  input  logic [CNT_W-1:0]       cmp0_val,
  input  logic [N_CMP*CNT_W-1:0] cmp_vals,
  input  logic                   cc0_en,
  input  logic                   cc0_ack,
  input  logic [N_CMP:0]         src_en,
  input  logic                   rd_stb,
  input  logic                   w1c_stb,
  input  logic [N_CMP:0]         w1c_mask,
  output logic [VEC_W-1:0]       vec_code,
  output logic                   irq_shared,
  output logic                   irq_cc0
);
  localparam int NF = N_CMP + 1;

  // Named internal events, brought out for the checker.
  logic          evt_cc0;
  logic [N_CMP-1:0] evt_cmp;
  logic          evt_wrap;
  logic [NF-1:0] set_vec;
  logic [NF-1:0] flags_q;
  logic [NF-1:0] pend;
  logic [NF-1:0] sel;
  logic [NF-1:0] rd_clr;
  logic [NF-1:0] clr_vec;
  logic          cc0_flag;

  tiv_evt_det #(.CNT_W(CNT_W), .N_CMP(N_CMP)) u_det (
    .clk(clk), .rst_n(rst_n), .count_i(tmr_count), .cmp0_i(cmp0_val),
    .cmp_i(cmp_vals), .evt_cc0_o(evt_cc0), .evt_cmp_o(evt_cmp),
    .evt_wrap_o(evt_wrap)
  );

  assign set_vec = {evt_wrap, evt_cmp};
  assign pend    = flags_q & src_en;

  tiv_prio_enc #(.NF(NF), .N_CMP(N_CMP), .VEC_W(VEC_W), .WRAP_CODE(WRAP_CODE)) u_enc (
    .req_i(pend), .sel_o(sel), .code_o(vec_code)
  );

  assign rd_clr  = rd_stb ? sel : '0;
  assign clr_vec = rd_clr | (w1c_stb ? w1c_mask : '0);

  tiv_flag_bank #(.NF(NF)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .flags_o(flags_q)
  );

  tiv_flag_bank #(.NF(1)) u_cc0 (
    .clk(clk), .rst_n(rst_n), .set_i(evt_cc0), .clr_i(cc0_ack), .flags_o(cc0_flag)
  );

  assign irq_shared = |pend;
  assign irq_cc0    = cc0_flag & cc0_en;
endmodule

// File: rtl/timer_irq_vector_chk.sv
module timer_irq_vector_chk #(
  parameter int NF    = 3,
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [VEC_W-1:0] vec_code,
  input logic             irq_shared,
  input logic             irq_cc0,
  input logic             cc0_ack,
  input logic             evt_cc0,
  input logic             w1c_stb,
  input logic [NF-1:0]    w1c_mask,
  input logic [NF-1:0]    set_vec,
  input logic [NF-1:0]    flags_q,
  input logic [NF-1:0]    pend,
  input logic [NF-1:0]    rd_clr
);
  p_irq_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared == (vec_code != '0));

  p_one_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_clr));

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (vec_code == '0));

  p_cc0_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cc0_ack && !evt_cc0) |=> !irq_cc0);

  p_reset_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (flags_q == '0) && !irq_shared);

  for (genvar g = 0; g < NF; g++) begin : g_bit
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr[g] && !set_vec[g]) |=> !flags_q[g]);
    p_set_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[g] |=> flags_q[g]);
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c_stb && w1c_mask[g] && !set_vec[g]) |=> !flags_q[g]);
  end
endmodule

bind timer_irq_vector timer_irq_vector_chk #(.NF(NF), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_code(vec_code), .irq_shared(irq_shared),
  .irq_cc0(irq_cc0), .cc0_ack(cc0_ack), .evt_cc0(evt_cc0), .w1c_stb(w1c_stb),
  .w1c_mask(w1c_mask), .set_vec(set_vec), .flags_q(flags_q), .pend(pend),
  .rd_clr(rd_clr)
);

// File: tb/timer_irq_vector_tb.sv
`timescale 1ns/1ps
module timer_irq_vector_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tmr_count = '0;
  logic [7:0] cmp0_val = 8'd3;
  logic [15:0] cmp_vals = {8'd9, 8'd5};
  logic       cc0_en = 1'b1, cc0_ack = 1'b0;
  logic [2:0] src_en = 3'b111;
  logic       rd_stb = 1'b0, w1c_stb = 1'b0;
  logic [2:0] w1c_mask = '0;
  logic [3:0] vec_code;
  logic       irq_shared, irq_cc0;
  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  timer_irq_vector u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_count(tmr_count), .cmp0_val(cmp0_val),
    .cmp_vals(cmp_vals), .cc0_en(cc0_en), .cc0_ack(cc0_ack), .src_en(src_en),
    .rd_stb(rd_stb), .w1c_stb(w1c_stb), .w1c_mask(w1c_mask),
    .vec_code(vec_code), .irq_shared(irq_shared), .irq_cc0(irq_cc0)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 5000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic go(input logic [7:0] v);
    tmr_count = v; step();
  endtask

  task automatic rd();
    rd_stb = 1'b1; step(); rd_stb = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tmr_count = '0; src_en = 3'b111; cc0_en = 1'b1;
    rd_stb = 0; w1c_stb = 0; cc0_ack = 0; w1c_mask = '0;
    step(); step(); rst_n = 1'b1; step();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 vec", vec_code, 0);
    chk("R10 irq_shared", irq_shared, 0);
    chk("R10 irq_cc0", irq_cc0, 0);
  endtask

  task automatic t_compare();
    do_reset();
    go(8'd4);
    chk("R1 no match", vec_code, 0);
    go(8'd5);
    chk("R1 ch1 match", vec_code, 2);
    chk("R4 irq on", irq_shared, 1);
    rd();
    chk("R5 cleared", vec_code, 0);
    chk("R4 irq off", irq_shared, 0);
    step(); step();
    chk("R1 held count no reset", vec_code, 0);
  endtask

  task automatic t_wrap();
    do_reset();
    go(8'd7); go(8'd0);
    chk("R2 wrap", vec_code, 4'hA);
  endtask

  task automatic t_priority();
    do_reset();
    go(8'd5); go(8'd9); go(8'd0);
    chk("R3 ch1 first", vec_code, 2);
    rd();
    chk("R5 next ch2", vec_code, 4);
    chk("R5 irq stays", irq_shared, 1);
    rd();
    chk("R3 wrap last", vec_code, 4'hA);
    rd();
    chk("R5 all clear", vec_code, 0);
    chk("R4 irq drop", irq_shared, 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    go(8'd5);
    rd_stb = 1'b1; tmr_count = 8'd9; step(); rd_stb = 1'b0;
    chk("R6 other set during read", vec_code, 4);
    rd();
    go(8'd5); go(8'd6);
    rd_stb = 1'b1; tmr_count = 8'd5; step(); rd_stb = 1'b0;
    chk("R6 same flag reset during read", vec_code, 2);
    rd();
    go(8'd9); go(8'd8);
    w1c_stb = 1'b1; w1c_mask = 3'b010; tmr_count = 8'd9; step(); w1c_stb = 1'b0;
    chk("R6 set beats w1c", vec_code, 4);
  endtask

  task automatic t_enable();
    do_reset();
    src_en = 3'b000;
    go(8'd5);
    chk("R7 masked vec", vec_code, 0);
    chk("R7 masked irq", irq_shared, 0);
    rd();
    src_en = 3'b001; step();
    chk("R11 idle read kept flag", vec_code, 2);
    go(8'd9);
    src_en = 3'b010; step();
    chk("R3 enable skips ch1", vec_code, 4);
  endtask

  task automatic t_w1c();
    do_reset();
    go(8'd5); go(8'd9); go(8'd0);
    w1c_stb = 1'b1; w1c_mask = 3'b010; step(); w1c_stb = 1'b0;
    chk("R8 ch1 untouched", vec_code, 2);
    rd();
    chk("R8 ch2 gone", vec_code, 4'hA);
    w1c_stb = 1'b1; w1c_mask = 3'b000; step(); w1c_stb = 1'b0;
    chk("R8 zero mask", vec_code, 4'hA);
    w1c_stb = 1'b1; w1c_mask = 3'b100; step(); w1c_stb = 1'b0;
    chk("R8 wrap gone", vec_code, 0);
  endtask

  task automatic t_cc0();
    do_reset();
    go(8'd3);
    chk("R9 cc0 irq", irq_cc0, 1);
    chk("R9 not in vec", vec_code, 0);
    cc0_ack = 1'b1; step(); cc0_ack = 1'b0;
    chk("R9 ack clears", irq_cc0, 0);
    cc0_en = 1'b0;
    go(8'd4); go(8'd3);
    chk("R9 masked", irq_cc0, 0);
    cc0_en = 1'b1; step();
    chk("R9 enabled later", irq_cc0, 1);
  endtask

  initial begin
    t_reset();
    t_compare();
    t_wrap();
    t_priority();
    t_same_cycle();
    t_enable();
    t_w1c();
    t_cc0();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule